// File: doc/BRIEF.md
# Radio Operation Inhibit Gate

This block sits between the radio slot scheduler and the radio front-end control. The scheduler raises one request line per kind of operation: clear-channel assessment, packet transmit or packet receive. The gate grants at most one of them and then tracks that operation until the radio reports that it has finished. An external device can hold a single inhibit line high to keep the radio quiet, for example while a sensitive sensor is being sampled. While inhibit is in force, every new request is refused with a one-cycle deny pulse, so the scheduler can skip that slot.

Inhibit works at the level of whole operations. An operation that was already granted is never cut short. It runs until its done indication arrives, and only the requests after it are refused. The inhibit line is asynchronous to the block and passes through a two-flop synchronizer before it is used. A status output reports when the radio is actually quiet, which means inhibit is in force and no operation is still running.

Top module: `rig_gate`

## Requirements
- R1: During reset and on the first cycle after it, op_grant, op_deny and inhibited are all zero. Reset also clears any tracked operation, so a request after reset is granted.
- R2: With inhibit low and no operation running, a request on op_req bit k gives a one-cycle pulse on op_grant bit k after the next rising edge. Bit 0 is clear-channel assessment, bit 1 is transmit and bit 2 is receive.
- R3: If several request bits are high at once, only the lowest-numbered bit is granted. op_grant never has more than one bit set.
- R4: From a grant until op_done is sampled, requests produce neither a grant nor a deny.
- R5: The edge that samples op_done ends the tracked operation, and a request on the following cycle can be granted.
- R6: While the synchronized inhibit is high, no grant is issued. Every request bit that is high is answered by its op_deny bit after the next edge.
- R7: inhibit_in is sampled through two flops. A request sampled on the second rising edge after inhibit_in rises is still granted. A request sampled on the third edge, which is the cycle in which the synchronized inhibit first becomes active, is denied.
- R8: If inhibit arrives while an operation is running, that operation is not aborted and inhibited stays low. inhibited goes high after the edge that samples op_done.
- R9: inhibited is high while the synchronized inhibit is high and no operation is running. After inhibit_in falls, inhibited goes low on the second rising edge, and requests after that edge are granted again.
- R10: While inhibited, several simultaneous requests are all denied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inhibit_in | input | 1 | External inhibit, active high, asynchronous; tie low when unused |
| op_req | input | NUM_OPS | Request per operation: bit 0 CCA, bit 1 transmit, bit 2 receive |
| op_done | input | 1 | Radio reports that the granted operation has finished |
| op_grant | output | NUM_OPS | One-cycle grant pulse per operation |
| op_deny | output | NUM_OPS | One-cycle pulse: the request was refused because of inhibit |
| inhibited | output | 1 | Radio quiet: inhibit in force and no operation running |

## Verification
The state that can go wrong is the operation-busy flag and the synchronized inhibit value. A busy flag that stays set shows up on the first later request as a missing grant. A busy flag that clears too early shows up as an unwanted grant, or as inhibited rising before op_done. A synchronizer with the wrong depth moves the grant/deny boundary by one edge relative to inhibit_in, and the same error moves the release of inhibited. Each of these faults appears at the ports within one cycle of the request or status change that exposes it.

// File: rtl/rig_pkg.sv
// Shared definitions for the radio inhibit gate.
// Assumes the operation index order below is also the grant priority.
package rig_pkg;
    localparam int RIG_OPS = 3;

    typedef enum logic [1:0] {
        OP_CCA = 2'd0,
        OP_TX  = 2'd1,
        OP_RX  = 2'd2
    } rig_op_e;
endpackage

// File: rtl/rig_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2 and that the input is a slow level, not a pulse.
module rig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the async level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rig_arbiter.sv
// Fixed-priority picker: the lowest index among the set request bits wins.
// Purely combinational, and the output is onehot0.
module rig_arbiter #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // ripple a "higher priority already requesting" flag upward
    for (genvar i = 0; i < N; i++) begin : g_pick
        assign seen[i+1] = seen[i] | req[i];
        assign pick[i]   = req[i] & ~seen[i];
    end
endmodule

// File: rtl/rig_tracker.sv
// Tracks whether a granted radio operation is still running.
// Assumes op_done is only meaningful while an operation is running.
module rig_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op_done,
    output logic active
);
    // set on grant decision, clear on completion
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= 1'b0;
        else if (start)   active <= 1'b1;
        else if (op_done) active <= 1'b0;
    end
endmodule

// File: rtl/rig_gate.sv
// Radio inhibit gate: grants one radio operation at a time and refuses
// every request while the synchronized inhibit is high. An operation that
// is already running completes normally.
// Assumes the scheduler drops a request once it has been granted or denied.
module rig_gate
    import rig_pkg::*;
#(
    parameter int NUM_OPS     = RIG_OPS,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inhibit_in,
    input  logic [NUM_OPS-1:0] op_req,
    input  logic               op_done,
    output logic [NUM_OPS-1:0] op_grant,
    output logic [NUM_OPS-1:0] op_deny,
    output logic               inhibited
);
    logic               inh_sync;
    logic               op_active;
    logic [NUM_OPS-1:0] pick;
    logic [NUM_OPS-1:0] gnt_d;
    logic [NUM_OPS-1:0] deny_d;

    rig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (inhibit_in),
        .q     (inh_sync)
    );

    rig_arbiter #(.N(NUM_OPS)) u_arb (
        .req  (op_req),
        .pick (pick)
    );

    // decide grant or deny for this cycle's requests
    always_comb begin
        gnt_d  = '0;
        deny_d = '0;
        if (inh_sync)        deny_d = op_req;
        else if (!op_active) gnt_d  = pick;
    end

    rig_tracker u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (|gnt_d),
        .op_done (op_done),
        .active  (op_active)
    );

    // register the one-cycle grant and deny pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_grant <= '0;
            op_deny  <= '0;
        end else begin
            op_grant <= gnt_d;
            op_deny  <= deny_d;
        end
    end

    assign inhibited = inh_sync & ~op_active;
endmodule

// File: rtl/rig_gate_chk.sv
// Property checker for rig_gate, attached through bind.
// Observes ports plus the synchronized inhibit and the busy flag.
module rig_gate_chk #(
    parameter int NUM_OPS = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OPS-1:0] op_req,
    input logic [NUM_OPS-1:0] op_grant,
    input logic [NUM_OPS-1:0] op_deny,
    input logic               inh_sync,
    input logic               op_active
);
    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_grant));

    p_no_grant_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inh_sync |=> (op_grant == '0));

    p_busy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_active && !inh_sync) |=> (op_grant == '0 && op_deny == '0));

    p_grant_starts_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|op_grant) |-> op_active);

    p_deny_only_requested_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_deny & ~$past(op_req)) == '0);
endmodule

bind rig_gate rig_gate_chk #(.NUM_OPS(NUM_OPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_req    (op_req),
    .op_grant  (op_grant),
    .op_deny   (op_deny),
    .inh_sync  (inh_sync),
    .op_active (op_active)
);

// File: tb/test_rig_gate.sv
`timescale 1ns/1ps
module test_rig_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inhibit_in = 1'b0;
    logic [2:0] op_req = '0;
    logic       op_done = 1'b0;
    logic [2:0] op_grant;
    logic [2:0] op_deny;
    logic       inhibited;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    rig_gate i_rig_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .inhibit_in (inhibit_in),
        .op_req     (op_req),
        .op_done    (op_done),
        .op_grant   (op_grant),
        .op_deny    (op_deny),
        .inhibited  (inhibited)
    );

    // {inhibit, req[2:0], done, exp_grant[2:0], exp_deny[2:0], exp_inhibited}
    localparam logic [11:0] VEC [0:16] = '{
        {1'b0, 3'b000, 1'b0, 3'b000, 3'b000, 1'b0}, // R2 idle
        {1'b0, 3'b001, 1'b0, 3'b001, 3'b000, 1'b0}, // R2 CCA grant
        {1'b0, 3'b010, 1'b0, 3'b000, 3'b000, 1'b0}, // R4 busy, ignored
        {1'b0, 3'b000, 1'b1, 3'b000, 3'b000, 1'b0}, // R5 done
        {1'b0, 3'b110, 1'b0, 3'b010, 3'b000, 1'b0}, // R3 TX over RX
        {1'b0, 3'b000, 1'b1, 3'b000, 3'b000, 1'b0}, // R5 done
        {1'b0, 3'b100, 1'b0, 3'b100, 3'b000, 1'b0}, // R2 RX grant
        {1'b0, 3'b000, 1'b1, 3'b000, 3'b000, 1'b0}, // R5 done
        {1'b1, 3'b000, 1'b0, 3'b000, 3'b000, 1'b0}, // R7 inhibit rises
        {1'b1, 3'b001, 1'b0, 3'b001, 3'b000, 1'b0}, // R7 second edge granted
        {1'b1, 3'b010, 1'b0, 3'b000, 3'b010, 1'b0}, // R7 third edge denied, R8 op runs
        {1'b1, 3'b000, 1'b1, 3'b000, 3'b000, 1'b1}, // R8 done -> inhibited
        {1'b1, 3'b111, 1'b0, 3'b000, 3'b111, 1'b1}, // R10 all denied, R6
        {1'b0, 3'b000, 1'b0, 3'b000, 3'b000, 1'b1}, // R9 still inhibited
        {1'b0, 3'b000, 1'b0, 3'b000, 3'b000, 1'b0}, // R9 released
        {1'b0, 3'b100, 1'b0, 3'b100, 3'b000, 1'b0}, // R9 grants resume
        {1'b0, 3'b000, 1'b1, 3'b000, 3'b000, 1'b0}  // R5 done
    };

    task automatic check(input string tag, input logic [2:0] eg,
                         input logic [2:0] ed, input logic ei);
        n_chk++;
        if (op_grant !== eg || op_deny !== ed || inhibited !== ei) begin
            n_bad++;
            $display("FAIL %s: grant=%b deny=%b inhibited=%b expected %b %b %b",
                     tag, op_grant, op_deny, inhibited, eg, ed, ei);
        end
    endtask

    task automatic step(input logic inh, input logic [2:0] rq, input logic dn);
        @(negedge clk);
        inhibit_in = inh;
        op_req     = rq;
        op_done    = dn;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R1 in reset", 3'b000, 3'b000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after reset", 3'b000, 3'b000, 1'b0);

        for (int i = 0; i < 17; i++) begin
            step(VEC[i][11], VEC[i][10:8], VEC[i][7]);
            check($sformatf("vector %0d", i), VEC[i][6:4], VEC[i][3:1], VEC[i][0]);
        end

        // R1: reset in the middle of an operation with inhibit high
        step(1'b0, 3'b001, 1'b0);
        check("R1 grant before reset", 3'b001, 3'b000, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        inhibit_in = 1'b1;
        op_req = 3'b000;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset clears inhibit", 3'b000, 3'b000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        inhibit_in = 1'b0;
        step(1'b0, 3'b010, 1'b0);
        check("R1 busy cleared by reset", 3'b010, 3'b000, 1'b0);
        step(1'b0, 3'b000, 1'b1);
        check("R5 done after reset test", 3'b000, 3'b000, 1'b0);

        // R4: a request together with done is still ignored on that cycle
        step(1'b0, 3'b001, 1'b0);
        check("R2 CCA grant", 3'b001, 3'b000, 1'b0);
        step(1'b0, 3'b100, 1'b1);
        check("R4 request with done ignored", 3'b000, 3'b000, 1'b0);
        step(1'b0, 3'b100, 1'b0);
        check("R5 grant after done", 3'b100, 3'b000, 1'b0);
        step(1'b0, 3'b000, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule